// File: doc/BRIEF.md
# Four-Channel Prescaled Pulse-Width Modulator

This block is a register-mapped pulse generator with four independent outputs. Each channel holds three words: a control word, a duty word and a period word. The control word carries the channel enable and a 14-bit clock divider. An extra master word gates all channels at once. Each channel counts input clocks through its divider and then through a 16-bit period counter. It drives its pin high for the first part of every period.

Software programs a channel through a single-cycle register port. The port has an address, a write strobe, write data and combinational read data. Duty, period and divider writes go to a holding copy. The running channel picks them up only when its current period ends, so a reprogram never cuts a pulse short or stretches it. Clearing an enable, at channel or master level, stops the channel and forces its pin low at once. Setting it again starts a clean period.

Top module: `pwm4_bank`

## Requirements
- R1: Channel n occupies the 16-byte block at byte address n×16. Its control word is at block offset 0, its duty word at offset 4 and its period word at offset 8. The master word is at byte address 0x3C. Only addresses whose two low bits are zero are mapped.
- R2: Reads return the last value written, masked to the implemented bits. In the control word these are bit 0 (enable) and bits 15:2 (divider). The duty and period words use bits 15:0, and the master word uses bit 0. Every other bit reads as zero.
- R3: A read of an unmapped address returns zero. Unmapped addresses are block offset 12 (other than 0x3C), any address at or above 0x40, and any address with a nonzero low bit pair. A write to such an address changes no register and no output.
- R4: After reset every register reads zero and every output is low.
- R5: With divider value P, duty value D and period value V, where 1 ≤ D < V, the output repeats every V×(P+1) clocks. In each repetition it is high for the first D×(P+1) clocks.
- R6: When the duty value is greater than or equal to the period value, the output stays high continuously.
- R7: While master bit 0 is clear, every output stays low, whatever the channel enables say.
- R8: Clearing a channel enable or the master enable drives the affected output low in the first cycle after the write edge.
- R9: When a channel becomes runnable, the output is low for the first cycle after the write edge. A fresh period then starts with its high portion in the following cycle.
- R10: A write to the duty, period or divider of a running channel takes effect at that channel's next period boundary. The pulse in progress keeps its old length.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for registers, dividers and counters |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_addr | input | 8 | Byte address of the register access |
| bus_we | input | 1 | Write strobe, captured at the rising clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| pwm_o | output | 4 | One pulse output per channel |

## Verification
On every cycle, the bound checker confirms four things. Outputs stay low while the master enable or their own channel enable is clear. A newly runnable channel starts low. Unmapped and masked read bits are zero. These properties hold regardless of the programmed values.

The pulse arithmetic needs the bench's scenarios to show it: high time and period scaling with the divider, the continuous-high case, and the deferral of a duty write to the next boundary. Each of these spans many cycles and depends on counting. The bench also covers readback after writes and writes to unmapped addresses being ignored.

// File: rtl/pwm4_bank_pkg.sv
// Package: shared widths, register word indices and the per-channel
// configuration record for the four-channel pulse generator.
// Assumes 32-bit register words laid out on 4-byte boundaries.
package pwm4_bank_pkg;

    localparam int CNT_W    = 16;   // duty / period counter width
    localparam int PRE_W    = 14;   // clock divider width
    localparam int PRE_LSB  = 2;    // divider field position in control word
    localparam int BLK_LSB  = 4;    // 16-byte channel block
    localparam int WORD_LSB = 2;    // 4-byte word

    // word index inside a channel block
    localparam logic [1:0] WRD_CTRL = 2'd0;
    localparam logic [1:0] WRD_DUTY = 2'd1;
    localparam logic [1:0] WRD_PER  = 2'd2;

    typedef struct packed {
        logic             en;
        logic [PRE_W-1:0] pre;
        logic [CNT_W-1:0] duty;
        logic [CNT_W-1:0] period;
    } chan_cfg_t;

endpackage

// File: rtl/pwm4_bank_presc.sv
// Clock divider: emits a one-cycle tick every (limit_i+1) clocks.
// clr_i holds the count at zero, so the first tick after a clear comes
// exactly limit_i+1 cycles later.
module pwm4_bank_presc
    import pwm4_bank_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic [PRE_W-1:0] limit_i,
    output logic             tick_o
);

    logic [PRE_W-1:0] div_q;

    assign tick_o = (div_q == limit_i);

    // advance the divider count, wrapping at the limit
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            div_q <= '0;
        end else if (tick_o) begin
            div_q <= '0;
        end else begin
            div_q <= div_q + PRE_W'(1);
        end
    end

endmodule

// File: rtl/pwm4_bank_chan.sv
// One pulse channel: divider, period counter and active settings copy.
// Settings from the register file are copied at start-up and at every
// period boundary only. Output is high while count < active duty.
// Assumes run_i is already the AND of master and channel enables.
module pwm4_bank_chan
    import pwm4_bank_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      run_i,
    input  chan_cfg_t cfg_i,
    output logic      pwm_o
);

    logic             live_q;
    logic [CNT_W-1:0] cnt_q;
    logic [PRE_W-1:0] act_pre_q;
    logic [CNT_W-1:0] act_duty_q;
    logic [CNT_W-1:0] act_per_q;
    logic             tick;
    logic             at_end;
    logic             presc_clr;

    assign presc_clr = !run_i || !live_q;
    assign at_end    = ({1'b0, cnt_q} + (CNT_W+1)'(1)) >= {1'b0, act_per_q};

    pwm4_bank_presc u_presc (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (presc_clr),
        .limit_i (act_pre_q),
        .tick_o  (tick)
    );

    // run state, period count and boundary loading of settings
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            live_q     <= 1'b0;
            cnt_q      <= '0;
            act_pre_q  <= '0;
            act_duty_q <= '0;
            act_per_q  <= '0;
        end else if (!run_i) begin
            live_q <= 1'b0;
            cnt_q  <= '0;
        end else if (!live_q) begin
            live_q     <= 1'b1;
            cnt_q      <= '0;
            act_pre_q  <= cfg_i.pre;
            act_duty_q <= cfg_i.duty;
            act_per_q  <= cfg_i.period;
        end else if (tick) begin
            if (at_end) begin
                cnt_q      <= '0;
                act_pre_q  <= cfg_i.pre;
                act_duty_q <= cfg_i.duty;
                act_per_q  <= cfg_i.period;
            end else begin
                cnt_q <= cnt_q + CNT_W'(1);
            end
        end
    end

    // output: high during the duty part of a live period
    always_comb begin
        pwm_o = live_q && run_i && (cnt_q < act_duty_q);
    end

endmodule

// File: rtl/pwm4_bank_regs.sv
// Register file: decodes word-aligned addresses into per-channel
// control, duty and period words plus one master word; provides
// combinational readback. Misaligned or unmapped accesses are ignored
// and read zero. The master word is decoded before channel blocks.
module pwm4_bank_regs
    import pwm4_bank_pkg::*;
#(
    parameter int          NUM_CH      = 4,
    parameter int          ADDR_W      = 8,
    parameter int          DATA_W      = 32,
    parameter logic [7:0]  MASTER_ADDR = 8'h3C
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              we,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output chan_cfg_t         cfg_o [NUM_CH],
    output logic              master_o
);

    localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

    logic              aligned;
    logic              hit_master;
    logic              in_chan;
    logic [CH_W-1:0]   sel_ch;
    logic [1:0]        sel_word;
    logic              unused_wbits;

    assign unused_wbits = ^{wdata[DATA_W-1:CNT_W], wdata[1]};

    // address decode
    always_comb begin
        aligned    = (addr[WORD_LSB-1:0] == '0);
        hit_master = aligned && (addr == ADDR_W'(MASTER_ADDR));
        in_chan    = aligned && !hit_master
                     && ((addr >> BLK_LSB) < ADDR_W'(NUM_CH));
        sel_ch     = addr[BLK_LSB +: CH_W];
        sel_word   = addr[WORD_LSB +: 2];
    end

    // master enable register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            master_o <= 1'b0;
        end else if (we && hit_master) begin
            master_o <= wdata[0];
        end
    end

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        // per-channel control, duty and period registers
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cfg_o[g] <= '0;
            end else if (we && in_chan && (sel_ch == CH_W'(g))) begin
                case (sel_word)
                    WRD_CTRL: begin
                        cfg_o[g].en  <= wdata[0];
                        cfg_o[g].pre <= wdata[PRE_LSB +: PRE_W];
                    end
                    WRD_DUTY: cfg_o[g].duty   <= wdata[CNT_W-1:0];
                    WRD_PER:  cfg_o[g].period <= wdata[CNT_W-1:0];
                    default:  ;
                endcase
            end
        end
    end

    // readback multiplexer
    always_comb begin
        rdata = '0;
        if (hit_master) begin
            rdata[0] = master_o;
        end else if (in_chan) begin
            case (sel_word)
                WRD_CTRL: begin
                    rdata[0]                 = cfg_o[sel_ch].en;
                    rdata[PRE_LSB +: PRE_W]  = cfg_o[sel_ch].pre;
                end
                WRD_DUTY: rdata[CNT_W-1:0] = cfg_o[sel_ch].duty;
                WRD_PER:  rdata[CNT_W-1:0] = cfg_o[sel_ch].period;
                default:  rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/pwm4_bank.sv
// Top level: register file plus one pulse channel per output.
// A channel runs only when both the master enable and its own enable
// are set. Register accesses complete in the cycle they are presented.
module pwm4_bank
    import pwm4_bank_pkg::*;
#(
    parameter int         NUM_CH      = 4,
    parameter int         ADDR_W      = 8,
    parameter int         DATA_W      = 32,
    parameter logic [7:0] MASTER_ADDR = 8'h3C
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [NUM_CH-1:0] pwm_o
);

    chan_cfg_t         cfg [NUM_CH];
    logic              master_en;
    logic [NUM_CH-1:0] ch_en;

    pwm4_bank_regs #(
        .NUM_CH      (NUM_CH),
        .ADDR_W      (ADDR_W),
        .DATA_W      (DATA_W),
        .MASTER_ADDR (MASTER_ADDR)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .addr     (bus_addr),
        .we       (bus_we),
        .wdata    (bus_wdata),
        .rdata    (bus_rdata),
        .cfg_o    (cfg),
        .master_o (master_en)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
        assign ch_en[g] = cfg[g].en;

        pwm4_bank_chan u_chan (
            .clk   (clk),
            .rst_n (rst_n),
            .run_i (master_en && ch_en[g]),
            .cfg_i (cfg[g]),
            .pwm_o (pwm_o[g])
        );
    end

endmodule

// File: rtl/pwm4_bank_chk.sv
// Checker for pwm4_bank: enable gating of outputs, start-up level,
// reset state and zero reads of unmapped or unimplemented bits.
module pwm4_bank_chk #(
    parameter int         NUM_CH      = 4,
    parameter int         ADDR_W      = 8,
    parameter int         DATA_W      = 32,
    parameter logic [7:0] MASTER_ADDR = 8'h3C
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] rdata,
    input logic [NUM_CH-1:0] pwm,
    input logic              master_en,
    input logic [NUM_CH-1:0] ch_en
);

    logic [NUM_CH-1:0] runnable;
    logic              is_master;
    logic              unmapped;

    assign runnable  = ch_en & {NUM_CH{master_en}};
    assign is_master = (addr == ADDR_W'(MASTER_ADDR));
    assign unmapped  = !is_master && ((addr[1:0] != 2'b00)
                       || (addr[3:2] == 2'b11)
                       || ((addr >> 4) >= ADDR_W'(NUM_CH)));

    // R7
    master_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !master_en |-> (pwm == '0));

    // R8
    chan_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((pwm & ~ch_en) == '0));

    // R3
    unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        unmapped |-> (rdata == '0));

    // R2
    ctrl_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!unmapped && !is_master && addr[3:2] == 2'b00)
            |-> (rdata[DATA_W-1:16] == '0 && rdata[1] == 1'b0));

    // R4
    reset_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (pwm == '0));

    for (genvar i = 0; i < NUM_CH; i++) begin : g_start
        // R9
        start_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (runnable[i] && !$past(runnable[i])) |-> !pwm[i]);
    end

endmodule

bind pwm4_bank pwm4_bank_chk #(
    .NUM_CH      (NUM_CH),
    .ADDR_W      (ADDR_W),
    .DATA_W      (DATA_W),
    .MASTER_ADDR (MASTER_ADDR)
) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .addr      (bus_addr),
    .rdata     (bus_rdata),
    .pwm       (pwm_o),
    .master_en (master_en),
    .ch_en     (ch_en)
);

// File: tb/test_pwm4_bank.sv
// Bench for pwm4_bank: a vector table of channel settings measured at
// the outputs, then directed readback, gating, start and reload tests.
module test_pwm4_bank;

    localparam int CLK_PERIOD = 10;
    localparam int NV = 6;
    // {channel, divider, duty, period}
    localparam int VEC [NV][4] = '{
        '{0, 0, 3, 8},
        '{1, 1, 2, 5},
        '{2, 3, 1, 4},
        '{3, 0, 1, 2},
        '{0, 2, 4, 7},
        '{1, 0, 9, 10}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [3:0]  pwm_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pwm4_bank i_pwm4_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pwm_o     (pwm_o)
    );

    task automatic check(input string req, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // called at a falling edge; the write lands on the next rising edge
    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_addr  = a;
        bus_wdata = d;
        bus_we    = 1'b1;
        @(negedge clk);
        bus_we    = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    // measure one full high/low cycle of output ch, sampled at falling edges
    task automatic meas(input int ch, output int hi, output int per);
        int g = 0;
        while (pwm_o[ch] !== 1'b0 && g < 4000) begin @(negedge clk); g++; end
        while (pwm_o[ch] !== 1'b1 && g < 4000) begin @(negedge clk); g++; end
        hi = 0;
        while (pwm_o[ch] === 1'b1 && g < 4000) begin hi++; @(negedge clk); g++; end
        per = hi;
        while (pwm_o[ch] === 1'b0 && g < 4000) begin per++; @(negedge clk); g++; end
    endtask

    // watchdog: a hung run counts as a failure
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL R5 watchdog expired actual=1 expected=0");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        int hi, per, cnt;

        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R4: reset state
        check("R4 outputs", pwm_o, 0);
        rd(8'h00, d); check("R4 ctrl0", d, 0);
        rd(8'h14, d); check("R4 duty1", d, 0);
        rd(8'h38, d); check("R4 per3", d, 0);
        rd(8'h3C, d); check("R4 master", d, 0);

        wr(8'h3C, 32'h1);

        // R5 R1: vector table across channels
        for (int v = 0; v < NV; v++) begin
            logic [7:0] base;
            base = 8'(VEC[v][0] * 16);
            wr(base + 8'h4, 32'(VEC[v][2]));
            wr(base + 8'h8, 32'(VEC[v][3]));
            wr(base, 32'((VEC[v][1] << 2) | 1));
            meas(VEC[v][0], hi, per);
            check("R5 high time", hi, VEC[v][2] * (VEC[v][1] + 1));
            check("R5 period", per, VEC[v][3] * (VEC[v][1] + 1));
            wr(base, 32'h0);
        end

        // R6: duty >= period stays high
        wr(8'h14, 32'd12);
        wr(8'h18, 32'd5);
        wr(8'h10, 32'h5);
        @(negedge clk);
        cnt = 0;
        for (int i = 0; i < 30; i++) begin
            if (pwm_o[1] === 1'b1) cnt++;
            @(negedge clk);
        end
        check("R6 continuous high", cnt, 30);
        wr(8'h10, 32'h0);

        // R10: duty write mid-pulse waits for the boundary
        wr(8'h24, 32'd2);
        wr(8'h28, 32'd10);
        wr(8'h20, 32'h1);
        cnt = 0;
        while (pwm_o[2] !== 1'b1 && cnt < 100) begin @(negedge clk); cnt++; end
        hi = 1;
        wr(8'h24, 32'd7);
        while (pwm_o[2] === 1'b1 && hi < 100) begin hi++; @(negedge clk); end
        check("R10 pulse in progress keeps old duty", hi, 2);
        meas(2, hi, per);
        check("R10 next pulse uses new duty", hi, 7);
        check("R10 period unchanged", per, 10);

        // R2 R1: readback masks
        wr(8'h20, 32'hFFFF_FFFF);
        rd(8'h20, d); check("R2 ctrl mask", d, 32'h0000_FFFD);
        wr(8'h28, 32'hABCD_1234);
        rd(8'h28, d); check("R2 period mask", d, 32'h0000_1234);
        wr(8'h24, 32'h0000_BEEF);
        rd(8'h24, d); check("R2 duty readback", d, 32'h0000_BEEF);
        rd(8'h3C, d); check("R2 master readback", d, 1);
        wr(8'h20, 32'h0);

        // R3: unmapped reads zero, writes ignored
        rd(8'h2C, d); check("R3 offset 12 reads zero", d, 0);
        rd(8'h40, d); check("R3 high address reads zero", d, 0);
        rd(8'h21, d); check("R3 misaligned reads zero", d, 0);
        wr(8'h01, 32'h5);
        rd(8'h00, d); check("R3 misaligned write ignored", d, 0);
        repeat (3) @(negedge clk);
        check("R3 output untouched", pwm_o[0], 0);

        // R7: master clear gates an enabled channel
        wr(8'h3C, 32'h0);
        wr(8'h04, 32'd3);
        wr(8'h08, 32'd8);
        wr(8'h00, 32'h1);
        cnt = 0;
        for (int i = 0; i < 40; i++) begin
            if (pwm_o[0] === 1'b1) cnt++;
            @(negedge clk);
        end
        check("R7 master off keeps output low", cnt, 0);

        // R9: fresh period on enable
        wr(8'h3C, 32'h1);
        check("R9 low right after enable", pwm_o[0], 0);
        @(negedge clk);
        check("R9 high next cycle", pwm_o[0], 1);

        // R8: channel disable takes effect at once
        wr(8'h00, 32'h0);
        check("R8 channel disable low", pwm_o[0], 0);

        // R8: master disable takes effect at once
        wr(8'h00, 32'h1);
        @(negedge clk);
        check("R8 running before master clear", pwm_o[0], 1);
        wr(8'h3C, 32'h0);
        check("R8 master disable low", pwm_o[0], 0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule